// File: doc/BRIEF.md
# Hardware Breakpoint Comparator

This unit sits beside a processor core and watches two kinds of activity every clock cycle: the program counter of the instruction being issued, and data accesses. Each data access arrives as a space tag, an address, a data byte and separate read and write strobes. The space tag selects program memory, internal direct data memory, special function registers or external data memory. When an armed breakpoint condition is met, the unit raises a halt request for the debug controller. It also keeps a sticky record of which breakpoint slot caused the halt.

A debug controller loads each breakpoint slot through a one-cycle register-write port. A slot holds:
- an enable bit;
- a kind: program-counter match, write access or read access;
- a target space;
- a 24-bit address;
- a data byte, and a bit that makes that byte a required match.

The controller clears status bits with a write-one-to-clear mask. The halt request is a one-cycle pulse, so a halt/step sequencer can treat each pulse as a single event.

Top module: `bkpt_watch`

## Requirements
- R1: After reset, `halt_req` is 0, `hit_status` is all zeros and every slot is disabled, so no bus or program-counter activity causes a hit until a slot is configured.
- R2: A slot of kind 0 (program counter) hits in a cycle where `pc_valid` is 1 and `pc` equals the slot address on all 24 bits. Its space field, the bus strobes and the bus data have no effect on it.
- R3: A slot of kind 1 (write) hits when `bus_wr` is 1, `bus_space` equals the slot space and the address compares equal. A read strobe alone does not trigger it.
- R4: A slot of kind 2 (read) hits when `bus_rd` is 1, `bus_space` equals the slot space and the address compares equal. A write strobe alone does not trigger it.
- R5: When the data-match bit of a write or read slot is 1, `bus_data` must also equal the slot data byte. When that bit is 0, the data is not compared. A program-counter slot never compares data.
- R6: Space codes are 0 for program memory, 1 for internal data, 2 for special function registers and 3 for external data. Spaces 0 and 3 compare all 24 address bits. Spaces 1 and 2 compare only address bits 7:0.
- R7: A slot with enable 0, or with kind 3, never hits, whatever the activity.
- R8: `halt_req` is 1 for exactly one cycle: the cycle after the first cycle of an unbroken run of cycles in which any slot hits. A later run, after at least one cycle with no hit, gives a new pulse.
- R9: Bit i of `hit_status` is set in the cycle after slot i hits. It stays set until a cycle with `clr_we` equal to 1 and bit i of `clr_mask` equal to 1. When a new hit and a clear fall in the same cycle, the hit wins.
- R10: A cycle with `cfg_we` equal to 1 loads every field of slot `cfg_slot`. The new settings take effect from the next cycle, and the other slots are left unchanged.
- R11: When several slots hit in the same cycle, all their status bits are set and only one halt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the slot selected by `cfg_slot` |
| cfg_slot | input | 2 | Index of the slot to load |
| cfg_enable | input | 1 | Slot enable value |
| cfg_kind | input | 2 | 0 program counter, 1 write, 2 read, 3 inactive |
| cfg_space | input | 2 | Target space code (R6) |
| cfg_data_en | input | 1 | Require a data byte match |
| cfg_addr | input | 24 | Breakpoint address |
| cfg_data | input | 8 | Required data byte |
| clr_we | input | 1 | Apply the status clear mask |
| clr_mask | input | 4 | Write-one-to-clear mask for `hit_status` |
| pc_valid | input | 1 | `pc` holds an issued instruction address |
| pc | input | 24 | Program counter |
| bus_space | input | 2 | Space code of the current access |
| bus_addr | input | 24 | Access address |
| bus_data | input | 8 | Access data byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| halt_req | output | 1 | One-cycle halt request |
| hit_status | output | 4 | Sticky per-slot hit record |

## Verification
A corrupted slot register shows up as a missing or unexpected `halt_req` pulse and status bit one cycle after the matching activity. A stuck match-history flop shows up either as a second pulse during a held match, or as no pulse at all on a fresh match. A wrong status update shows as a bit that drops without a clear, or that survives one, at the very next cycle. The bench therefore checks both outputs exactly one cycle after each stimulus and keeps watching while matches are held and while clears are issued.

// File: rtl/bkpt_pkg.sv
// Shared encodings for the breakpoint comparator.
// Assumes two-bit space and kind fields, as stated in the block requirements.
package bkpt_pkg;

    typedef enum logic [1:0] {
        SPC_CODE  = 2'd0,
        SPC_IDATA = 2'd1,
        SPC_SFR   = 2'd2,
        SPC_XDATA = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        KND_PC    = 2'd0,
        KND_WRITE = 2'd1,
        KND_READ  = 2'd2,
        KND_NONE  = 2'd3
    } kind_e;

endpackage

// File: rtl/bkpt_addr_match.sv
// Space-aware address equality.
// Program and external data spaces compare the full address width.
// Internal data and special function register spaces compare only the
// low NARROW_W bits. Purely combinational.
module bkpt_addr_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int NARROW_W = 8
) (
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              equal
);

    // Choose the comparison width from the space code.
    always_comb begin
        case (space_e'(space))
            SPC_IDATA, SPC_SFR: equal = (addr_a[NARROW_W-1:0] == addr_b[NARROW_W-1:0]);
            default:            equal = (addr_a == addr_b);
        endcase
    end

endmodule

// File: rtl/bkpt_slot.sv
// One breakpoint slot: a configuration register plus its match logic.
// The hit output is combinational from the current activity and the
// stored configuration. Loading takes effect on the following cycle.
module bkpt_slot
    import bkpt_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 8,
    parameter int NARROW_W = 8,
    parameter int SLOT_W   = 2,
    parameter int SLOT_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_kind,
    input  logic [1:0]        cfg_space,
    input  logic              cfg_data_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [1:0]        bus_space,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              hit
);

    localparam logic [SLOT_W-1:0] MY_ID = SLOT_W'(SLOT_ID);

    logic              en_q;
    kind_e             kind_q;
    logic [1:0]        space_q;
    logic              den_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    logic bus_addr_eq;
    logic data_ok;
    logic space_ok;
    logic raw_hit;

    // Hold the slot configuration; reset leaves the slot disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            kind_q  <= KND_NONE;
            space_q <= 2'd0;
            den_q   <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (cfg_we && (cfg_slot == MY_ID)) begin
            en_q    <= cfg_enable;
            kind_q  <= kind_e'(cfg_kind);
            space_q <= cfg_space;
            den_q   <= cfg_data_en;
            addr_q  <= cfg_addr;
            data_q  <= cfg_data;
        end
    end

    bkpt_addr_match #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_amatch (
        .space  (space_q),
        .addr_a (bus_addr),
        .addr_b (addr_q),
        .equal  (bus_addr_eq)
    );

    // Data qualifier and space qualifier for bus accesses.
    always_comb begin
        data_ok  = !den_q || (bus_data == data_q);
        space_ok = (bus_space == space_q);
    end

    // Select the condition that belongs to the slot kind.
    always_comb begin
        case (kind_q)
            KND_PC:    raw_hit = pc_valid && (pc == addr_q);
            KND_WRITE: raw_hit = bus_wr && space_ok && bus_addr_eq && data_ok;
            KND_READ:  raw_hit = bus_rd && space_ok && bus_addr_eq && data_ok;
            default:   raw_hit = 1'b0;
        endcase
        hit = en_q && raw_hit;
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !hit); // R7
    AST_PC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KND_PC && !pc_valid) |-> !hit); // R2
    AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KND_WRITE && !bus_wr) |-> !hit); // R3
    AST_READ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == KND_READ && !bus_rd) |-> !hit); // R4

endmodule

// File: rtl/bkpt_collect.sv
// Combines the per-slot hits into a one-cycle halt pulse and a sticky
// status vector. A hit wins over a clear of the same bit in the same cycle.
module bkpt_collect #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] hit_vec,
    input  logic                 clr_we,
    input  logic [NUM_SLOTS-1:0] clr_mask,
    output logic                 halt_req,
    output logic [NUM_SLOTS-1:0] status
);

    logic                 any_hit;
    logic                 any_hit_q;
    logic [NUM_SLOTS-1:0] clr_eff;
    logic [NUM_SLOTS-1:0] keep_vec;

    // Reduce the slot hits and form the effective clear mask.
    always_comb begin
        any_hit  = |hit_vec;
        clr_eff  = clr_we ? clr_mask : '0;
        keep_vec = status & ~clr_eff;
    end

    // Edge-detect the hit run and keep the sticky record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_hit_q <= 1'b0;
            halt_req  <= 1'b0;
            status    <= '0;
        end else begin
            any_hit_q <= any_hit;
            halt_req  <= any_hit && !any_hit_q;
            status    <= keep_vec | hit_vec;
        end
    end

    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req); // R8
    AST_HALT_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (status != '0)); // R9
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_vec != '0) |=> ((status & $past(keep_vec)) == $past(keep_vec))); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && hit_vec == '0) |=> ((status & $past(clr_mask)) == '0)); // R9
    AST_ALL_HITS_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |=> ((status & $past(hit_vec)) == $past(hit_vec))); // R11

endmodule

// File: rtl/bkpt_watch.sv
// Top of the breakpoint comparator: NUM_SLOTS independent slots whose
// hits feed a shared halt pulse and status collector.
// Assumes one access and one program-counter value per cycle.
module bkpt_watch #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 8,
    parameter int NARROW_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [$clog2(NUM_SLOTS)-1:0] cfg_slot,
    input  logic                         cfg_enable,
    input  logic [1:0]                   cfg_kind,
    input  logic [1:0]                   cfg_space,
    input  logic                         cfg_data_en,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [DATA_W-1:0]            cfg_data,
    input  logic                         clr_we,
    input  logic [NUM_SLOTS-1:0]         clr_mask,
    input  logic                         pc_valid,
    input  logic [ADDR_W-1:0]            pc,
    input  logic [1:0]                   bus_space,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_data,
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    output logic                         halt_req,
    output logic [NUM_SLOTS-1:0]         hit_status
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] hit_vec;

    // One comparator slot per breakpoint.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        bkpt_slot #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .NARROW_W (NARROW_W),
            .SLOT_W   (SLOT_W),
            .SLOT_ID  (g)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (cfg_we),
            .cfg_slot    (cfg_slot),
            .cfg_enable  (cfg_enable),
            .cfg_kind    (cfg_kind),
            .cfg_space   (cfg_space),
            .cfg_data_en (cfg_data_en),
            .cfg_addr    (cfg_addr),
            .cfg_data    (cfg_data),
            .pc_valid    (pc_valid),
            .pc          (pc),
            .bus_space   (bus_space),
            .bus_addr    (bus_addr),
            .bus_data    (bus_data),
            .bus_rd      (bus_rd),
            .bus_wr      (bus_wr),
            .hit         (hit_vec[g])
        );
    end

    bkpt_collect #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .halt_req (halt_req),
        .status   (hit_status)
    );

endmodule

// File: tb/bkpt_watch_tb.sv
// Self-checking bench: a vector table for single-slot matching, then
// directed tests for reset, pulse shape, sticky status and multi-slot use.
module bkpt_watch_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_slot;
    logic        cfg_enable;
    logic [1:0]  cfg_kind;
    logic [1:0]  cfg_space;
    logic        cfg_data_en;
    logic [23:0] cfg_addr;
    logic [7:0]  cfg_data;
    logic        clr_we;
    logic [3:0]  clr_mask;
    logic        pc_valid;
    logic [23:0] pc;
    logic [1:0]  bus_space;
    logic [23:0] bus_addr;
    logic [7:0]  bus_data;
    logic        bus_rd;
    logic        bus_wr;
    logic        halt_req;
    logic [3:0]  hit_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bkpt_watch u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_enable(cfg_enable), .cfg_kind(cfg_kind), .cfg_space(cfg_space),
        .cfg_data_en(cfg_data_en), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .clr_we(clr_we), .clr_mask(clr_mask), .pc_valid(pc_valid), .pc(pc),
        .bus_space(bus_space), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .halt_req(halt_req),
        .hit_status(hit_status)
    );

    typedef struct packed {
        logic        en;
        logic [1:0]  kind;
        logic [1:0]  space;
        logic        den;
        logic [23:0] caddr;
        logic [7:0]  cdata;
        logic        pcv;
        logic [23:0] pcval;
        logic [1:0]  bsp;
        logic [23:0] baddr;
        logic [7:0]  bdata;
        logic        rd;
        logic        wr;
        logic        exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1,2'd0,2'd1,1'b0,24'h012345,8'h00, 1'b1,24'h012345,2'd0,24'h000000,8'h00,1'b0,1'b0, 1'b1}, // R2 pc equal
        '{1'b1,2'd0,2'd1,1'b0,24'h012345,8'h00, 1'b1,24'h012344,2'd0,24'h000000,8'h00,1'b0,1'b0, 1'b0}, // R2 pc differs
        '{1'b1,2'd0,2'd1,1'b0,24'h012345,8'h00, 1'b0,24'h012345,2'd1,24'h012345,8'h00,1'b1,1'b0, 1'b0}, // R2 no valid, bus ignored
        '{1'b1,2'd1,2'd3,1'b0,24'hABCDEF,8'h00, 1'b0,24'h000000,2'd3,24'hABCDEF,8'h11,1'b0,1'b1, 1'b1}, // R3 write hit
        '{1'b1,2'd1,2'd3,1'b0,24'hABCDEF,8'h00, 1'b0,24'h000000,2'd3,24'hABCDEF,8'h11,1'b1,1'b0, 1'b0}, // R3 read ignored
        '{1'b1,2'd1,2'd3,1'b0,24'hABCDEF,8'h00, 1'b0,24'h000000,2'd0,24'hABCDEF,8'h11,1'b0,1'b1, 1'b0}, // R3 wrong space
        '{1'b1,2'd2,2'd0,1'b0,24'h000400,8'h00, 1'b0,24'h000000,2'd0,24'h000400,8'h00,1'b1,1'b0, 1'b1}, // R4 read hit
        '{1'b1,2'd2,2'd0,1'b0,24'h000400,8'h00, 1'b0,24'h000000,2'd0,24'h000400,8'h00,1'b0,1'b1, 1'b0}, // R4 write ignored
        '{1'b1,2'd1,2'd3,1'b1,24'h001000,8'h5A, 1'b0,24'h000000,2'd3,24'h001000,8'h5A,1'b0,1'b1, 1'b1}, // R5 data equal
        '{1'b1,2'd1,2'd3,1'b1,24'h001000,8'h5A, 1'b0,24'h000000,2'd3,24'h001000,8'h5B,1'b0,1'b1, 1'b0}, // R5 data differs
        '{1'b1,2'd2,2'd3,1'b0,24'h001000,8'h5A, 1'b0,24'h000000,2'd3,24'h001000,8'h77,1'b1,1'b0, 1'b1}, // R5 data not required
        '{1'b1,2'd2,2'd1,1'b0,24'h000033,8'h00, 1'b0,24'h000000,2'd1,24'hFF0033,8'h00,1'b1,1'b0, 1'b1}, // R6 idata low byte
        '{1'b1,2'd1,2'd2,1'b0,24'h000080,8'h00, 1'b0,24'h000000,2'd2,24'h010080,8'h00,1'b0,1'b1, 1'b1}, // R6 sfr low byte
        '{1'b1,2'd1,2'd3,1'b0,24'h000080,8'h00, 1'b0,24'h000000,2'd3,24'h010080,8'h00,1'b0,1'b1, 1'b0}, // R6 xdata full width
        '{1'b0,2'd0,2'd0,1'b0,24'h012345,8'h00, 1'b1,24'h012345,2'd0,24'h000000,8'h00,1'b0,1'b0, 1'b0}, // R7 disabled
        '{1'b1,2'd3,2'd1,1'b0,24'h000033,8'h00, 1'b1,24'h000033,2'd1,24'h000033,8'h00,1'b1,1'b1, 1'b0}, // R7 kind 3
        '{1'b1,2'd0,2'd0,1'b1,24'h000777,8'hAA, 1'b1,24'h000777,2'd0,24'h000000,8'h00,1'b0,1'b0, 1'b1}  // R5 pc ignores data
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic pv, input logic [23:0] pcv, input logic [1:0] sp,
                         input logic [23:0] ad, input logic [7:0] dt,
                         input logic rd, input logic wr);
        pc_valid = pv; pc = pcv; bus_space = sp; bus_addr = ad;
        bus_data = dt; bus_rd = rd; bus_wr = wr;
    endtask

    task automatic idle_bus();
        drive(1'b0, 24'h0, 2'd0, 24'h0, 8'h0, 1'b0, 1'b0);
    endtask

    // Loads one slot during the next cycle, with the bus idle.
    task automatic load_slot(input logic [1:0] s, input logic en, input logic [1:0] k,
                             input logic [1:0] sp, input logic den,
                             input logic [23:0] ad, input logic [7:0] dt);
        @(negedge clk);
        idle_bus();
        clr_we = 1'b0;
        cfg_we = 1'b1; cfg_slot = s; cfg_enable = en; cfg_kind = k;
        cfg_space = sp; cfg_data_en = den; cfg_addr = ad; cfg_data = dt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        idle_bus();
        clr_we = 1'b1; clr_mask = 4'hF;
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    task automatic pulse_pc(input logic [23:0] v);
        drive(1'b1, v, 2'd0, 24'h0, 8'h0, 1'b0, 1'b0);
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = 2'd0; cfg_enable = 1'b0;
        cfg_kind = 2'd0; cfg_space = 2'd0; cfg_data_en = 1'b0;
        cfg_addr = 24'h0; cfg_data = 8'h0; clr_we = 1'b0; clr_mask = 4'h0;
        idle_bus();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, then activity at address 0 on all paths
        check("R1 halt after reset", 32'(halt_req), 32'd0);
        check("R1 status after reset", 32'(hit_status), 32'd0);
        drive(1'b1, 24'h0, 2'd0, 24'h0, 8'h0, 1'b1, 1'b1);
        @(negedge clk);
        idle_bus();
        check("R1 no hit before configuration", 32'(halt_req), 32'd0);
        check("R1 status stays clear", 32'(hit_status), 32'd0);

        // Vector table, slot 0 only
        for (int i = 0; i < NV; i++) begin
            load_slot(2'd0, VECS[i].en, VECS[i].kind, VECS[i].space,
                      VECS[i].den, VECS[i].caddr, VECS[i].cdata);
            clr_we = 1'b1; clr_mask = 4'hF;
            drive(VECS[i].pcv, VECS[i].pcval, VECS[i].bsp, VECS[i].baddr,
                  VECS[i].bdata, VECS[i].rd, VECS[i].wr);
            @(negedge clk);
            idle_bus();
            clr_we = 1'b0;
            check($sformatf("vector %0d halt (R2..R7)", i), 32'(halt_req), 32'(VECS[i].exp));
            check($sformatf("vector %0d status (R2..R7)", i), 32'(hit_status), 32'(VECS[i].exp));
        end

        // R8: held match gives a single pulse, a new run gives another
        load_slot(2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 24'h000100, 8'h00);
        clear_all();
        drive(1'b1, 24'h000100, 2'd0, 24'h0, 8'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 pulse on first match", 32'(halt_req), 32'd1);
        @(negedge clk);
        check("R8 no pulse while match held", 32'(halt_req), 32'd0);
        @(negedge clk);
        check("R8 still no pulse", 32'(halt_req), 32'd0);
        idle_bus();
        @(negedge clk);
        pulse_pc(24'h000100);
        check("R8 new pulse after gap", 32'(halt_req), 32'd1);
        @(negedge clk);
        check("R8 pulse is one cycle", 32'(halt_req), 32'd0);

        // R9: sticky record and write-one-to-clear
        repeat (2) @(negedge clk);
        check("R9 status held while idle", 32'(hit_status), 32'h1);
        clr_we = 1'b1; clr_mask = 4'h2;
        @(negedge clk);
        clr_we = 1'b0;
        check("R9 clear of other bit leaves bit 0", 32'(hit_status), 32'h1);
        clr_we = 1'b1; clr_mask = 4'h1;
        @(negedge clk);
        clr_we = 1'b0;
        check("R9 clear of own bit", 32'(hit_status), 32'h0);

        // R10: loading slot 2 leaves slot 0 intact
        load_slot(2'd2, 1'b1, 2'd0, 2'd0, 1'b0, 24'h000200, 8'h00);
        pulse_pc(24'h000200);
        check("R10 new slot fires", 32'(hit_status), 32'h4);
        check("R10 new slot halts", 32'(halt_req), 32'd1);
        clear_all();
        pulse_pc(24'h000100);
        check("R10 slot 0 unchanged", 32'(hit_status), 32'h1);

        // R9: hit wins over a same-cycle clear
        clr_we = 1'b1; clr_mask = 4'h4;
        drive(1'b1, 24'h000200, 2'd0, 24'h0, 8'h0, 1'b0, 1'b0);
        @(negedge clk);
        idle_bus();
        clr_we = 1'b0;
        check("R9 set wins over clear", 32'(hit_status), 32'h5);

        // R11: two slots on one address, one pulse
        load_slot(2'd1, 1'b1, 2'd0, 2'd3, 1'b0, 24'h000100, 8'h00);
        clear_all();
        drive(1'b1, 24'h000100, 2'd0, 24'h0, 8'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R11 both bits set", 32'(hit_status), 32'h3);
        check("R11 halt pulse", 32'(halt_req), 32'd1);
        @(negedge clk);
        idle_bus();
        check("R11 only one pulse", 32'(halt_req), 32'd0);

        // R1: reset mid-run clears status and disarms slots
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 status cleared by reset", 32'(hit_status), 32'h0);
        pulse_pc(24'h000100);
        check("R1 slots disarmed by reset", 32'(halt_req), 32'd0);
        check("R1 no status after reset", 32'(hit_status), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule